// File: doc/BRIEF.md
# Programmable Pin Debounce Filter

This block cleans up one input pin before it reaches edge or level detection. The raw pin level first passes through a flop synchronizer. The synchronized level is then compared against the filtered level that the block presents. When the two differ, a stability window opens. The filtered level only takes the new value once the window has run to its end without the input returning.

The window is timed by a slow real-time tick. That tick arrives as a one-cycle enable in the block's own clock domain. A two-bit unit select sets how many ticks make one step. A four-bit count sets how many steps make the window. A two-bit mode selects one of four behaviours:
- bypass, where the filter is not used;
- filtering of both polarities;
- a polarity-selective mode in which one direction of change passes at once and only the other direction is held to the window.

Top module: `pin_debounce_filter`

## Requirements
- R1: While reset is asserted and right after it is released, `pin_filt` is 0.
- R2: With `cfg_mode` = 2'b00 (bypass), `pin_filt` takes a new `pin_raw` level on the third rising clock edge after the change and not before. No tick is needed.
- R3: `cfg_unit` selects the ticks per step: 2'b00 selects UNIT0_TICKS, 2'b01 selects UNIT1_TICKS, 2'b10 selects UNIT2_TICKS and 2'b11 selects UNIT3_TICKS. The defaults are 2, 8, 512 and 2048.
- R4: In a filtering case, `pin_filt` changes on the clock edge that samples the (steps × ticks-per-step)-th tick. Only ticks seen while the synchronized input differs from `pin_filt` are counted. The output holds its value through every earlier tick. The number of steps is `cfg_count`.
- R5: A `cfg_count` of 0 with filtering active behaves exactly like a count of 1.
- R6: With `cfg_mode` = 2'b01, both rising and falling changes wait for the full window.
- R7: If the synchronized input returns to the `pin_filt` level before the window ends, all progress is discarded. A later change needs a full window again.
- R8: With `cfg_mode` = 2'b10, a falling change reaches `pin_filt` with the bypass latency of R2. A rising change waits for the full window.
- R9: With `cfg_mode` = 2'b11, a rising change reaches `pin_filt` with the bypass latency of R2. A falling change waits for the full window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rtc_tick | input | 1 | One-cycle real-time tick enable |
| pin_raw | input | 1 | Unsynchronized pin level |
| cfg_mode | input | 2 | 00 bypass, 01 both polarities filtered, 10 falling passes, 11 rising passes |
| cfg_unit | input | 2 | Step length select |
| cfg_count | input | CNT_W | Steps per window (0 treated as 1) |
| pin_filt | output | 1 | Filtered pin level |

## Verification
The bench keeps UNIT0_TICKS and UNIT1_TICKS at 2 and 8. It shrinks UNIT2_TICKS to 16 and UNIT3_TICKS to 32. With those values, all four unit selects can be exercised to their exact window boundary in a few hundred ticks, including a four-step window on the largest unit. Since the tick is supplied by the bench, each window is checked one tick before it closes and again on the closing tick.

// File: rtl/dbf_pkg.sv
package dbf_pkg;

  typedef enum logic [1:0] {
    DBF_BYPASS    = 2'b00,
    DBF_BOTH      = 2'b01,
    DBF_KEEP_LOW  = 2'b10,
    DBF_KEEP_HIGH = 2'b11
  } dbf_mode_e;

  // A change toward 'target' skips the window in the polarity-selective modes
  function automatic logic fast_pass(input dbf_mode_e m, input logic target);
    return ((m == DBF_KEEP_LOW) && !target) || ((m == DBF_KEEP_HIGH) && target);
  endfunction

  // Steps a window lasts; a zero count still means one step
  function automatic int unsigned step_goal(input int unsigned cnt);
    return (cnt == 0) ? 1 : cnt;
  endfunction

endpackage

// File: rtl/dbf_sync.sv
module dbf_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/dbf_prescaler.sv
module dbf_prescaler #(
  parameter int unsigned UNIT0_TICKS = 2,
  parameter int unsigned UNIT1_TICKS = 8,
  parameter int unsigned UNIT2_TICKS = 512,
  parameter int unsigned UNIT3_TICKS = 2048,
  parameter int unsigned TICK_W      = 11
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       rtc_tick,
  input  logic [1:0] unit_sel,
  output logic       step
);
  logic [TICK_W-1:0] tcnt;

  function automatic int unsigned unit_len(input logic [1:0] s);
    case (s)
      2'd0:    return UNIT0_TICKS;
      2'd1:    return UNIT1_TICKS;
      2'd2:    return UNIT2_TICKS;
      default: return UNIT3_TICKS;
    endcase
  endfunction

  assign step = run && rtc_tick && ((32'(tcnt) + 32'd1) >= unit_len(unit_sel));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        tcnt <= '0;
    else if (!run)     tcnt <= '0;
    else if (rtc_tick) tcnt <= step ? '0 : tcnt + 1'b1;
  end

  // A closed window leaves no tick progress behind
  assert_tick_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(run) |-> (tcnt == '0));
endmodule

// File: rtl/dbf_stab_counter.sv
module dbf_stab_counter #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             step,
  input  logic [CNT_W-1:0] count_cfg,
  output logic             done
);
  import dbf_pkg::*;

  logic [CNT_W-1:0] scnt;

  assign done = run && step &&
                ((32'(scnt) + 32'd1) >= step_goal(32'(count_cfg)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    scnt <= '0;
    else if (!run) scnt <= '0;
    else if (step) scnt <= done ? '0 : scnt + 1'b1;
  end

  // A closed window leaves no step progress behind
  assert_step_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(run) |-> (scnt == '0));
endmodule

// File: rtl/pin_debounce_filter.sv
module pin_debounce_filter #(
  parameter int unsigned CNT_W       = 4,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned UNIT0_TICKS = 2,
  parameter int unsigned UNIT1_TICKS = 8,
  parameter int unsigned UNIT2_TICKS = 512,
  parameter int unsigned UNIT3_TICKS = 2048
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rtc_tick,
  input  logic             pin_raw,
  input  logic [1:0]       cfg_mode,
  input  logic [1:0]       cfg_unit,
  input  logic [CNT_W-1:0] cfg_count,
  output logic             pin_filt
);
  import dbf_pkg::*;

  localparam int unsigned MAX_A     = (UNIT0_TICKS > UNIT1_TICKS) ? UNIT0_TICKS : UNIT1_TICKS;
  localparam int unsigned MAX_B     = (UNIT2_TICKS > UNIT3_TICKS) ? UNIT2_TICKS : UNIT3_TICKS;
  localparam int unsigned MAX_TICKS = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned TICK_W    = $clog2(MAX_TICKS + 1);

  dbf_mode_e mode;
  logic      sync_lvl;
  logic      filt_q;
  logic      differs;    // synchronized level disagrees with output
  logic      fast_take;  // change allowed through at once
  logic      win_open;   // stability window is running
  logic      step_evt;   // one step of the window elapsed
  logic      win_done;   // window completed on this cycle

  assign mode = dbf_mode_e'(cfg_mode);

  dbf_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_raw), .q(sync_lvl)
  );

  assign differs   = (sync_lvl != filt_q);
  assign fast_take = differs && fast_pass(mode, sync_lvl);
  assign win_open  = differs && (mode != DBF_BYPASS) && !fast_pass(mode, sync_lvl);

  dbf_prescaler #(
    .UNIT0_TICKS(UNIT0_TICKS), .UNIT1_TICKS(UNIT1_TICKS),
    .UNIT2_TICKS(UNIT2_TICKS), .UNIT3_TICKS(UNIT3_TICKS),
    .TICK_W(TICK_W)
  ) u_prescaler (
    .clk(clk), .rst_n(rst_n), .run(win_open), .rtc_tick(rtc_tick),
    .unit_sel(cfg_unit), .step(step_evt)
  );

  dbf_stab_counter #(.CNT_W(CNT_W)) u_stab (
    .clk(clk), .rst_n(rst_n), .run(win_open), .step(step_evt),
    .count_cfg(cfg_count), .done(win_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 filt_q <= 1'b0;
    else if (mode == DBF_BYPASS) filt_q <= sync_lvl;
    else if (fast_take || win_done) filt_q <= sync_lvl;
  end

  assign pin_filt = filt_q;

  assert_bypass_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == DBF_BYPASS && $past(cfg_mode) == 2'b00) |-> (filt_q == $past(sync_lvl)));

  assert_both_waits_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == DBF_BOTH && $past(cfg_mode) == cfg_mode && filt_q != $past(filt_q))
      |-> $past(rtc_tick));

  assert_keep_low_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == DBF_KEEP_LOW && $past(cfg_mode) == cfg_mode && $rose(filt_q))
      |-> $past(rtc_tick));

  assert_keep_high_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == DBF_KEEP_HIGH && $past(cfg_mode) == cfg_mode && $fell(filt_q))
      |-> $past(rtc_tick));
endmodule

// File: tb/pin_debounce_filter_bench.sv
module pin_debounce_filter_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rtc_tick = 1'b0;
  logic       pin_raw = 1'b0;
  logic [1:0] cfg_mode = 2'b00;
  logic [1:0] cfg_unit = 2'b00;
  logic [3:0] cfg_count = 4'd1;
  logic       pin_filt;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  pin_debounce_filter #(
    .CNT_W(4), .SYNC_STAGES(2),
    .UNIT0_TICKS(2), .UNIT1_TICKS(8), .UNIT2_TICKS(16), .UNIT3_TICKS(32)
  ) u_pin_debounce_filter (
    .clk(clk), .rst_n(rst_n), .rtc_tick(rtc_tick), .pin_raw(pin_raw),
    .cfg_mode(cfg_mode), .cfg_unit(cfg_unit), .cfg_count(cfg_count),
    .pin_filt(pin_filt)
  );

  // {mode[1:0], unit[1:0], count[3:0], start level, ticks to change (0 = at once)}
  localparam logic [16:0] VECS [11] = '{
    {2'b01, 2'b00, 4'd1,  1'b0, 8'd2},
    {2'b01, 2'b01, 4'd3,  1'b0, 8'd24},
    {2'b01, 2'b10, 4'd2,  1'b1, 8'd32},
    {2'b01, 2'b11, 4'd4,  1'b0, 8'd128},
    {2'b01, 2'b00, 4'd0,  1'b0, 8'd2},
    {2'b01, 2'b00, 4'd15, 1'b1, 8'd30},
    {2'b10, 2'b00, 4'd2,  1'b1, 8'd0},
    {2'b10, 2'b01, 4'd2,  1'b0, 8'd16},
    {2'b11, 2'b00, 4'd3,  1'b0, 8'd0},
    {2'b11, 2'b01, 4'd1,  1'b1, 8'd8},
    {2'b11, 2'b11, 4'd0,  1'b1, 8'd32}
  };

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: pin_filt=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick();
    @(negedge clk) rtc_tick = 1'b1;
    @(negedge clk) rtc_tick = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) tick();
  endtask

  function automatic string row_tag(input logic [16:0] v);
    if (v[12:9] == 4'd0) return "R5";
    case (v[16:15])
      2'b01:   return "R3 R4 R6";
      2'b10:   return "R8";
      default: return "R9";
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: pin_filt=%0b expected=finish", pin_filt);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    // R1: reset value
    wait_n(3);
    check("R1", pin_filt, 1'b0);
    rst_n = 1'b1;
    check("R1", pin_filt, 1'b0);

    // R2: bypass latency is three edges
    @(negedge clk) pin_raw = 1'b1;
    wait_n(2);
    check("R2", pin_filt, 1'b0);
    wait_n(1);
    check("R2", pin_filt, 1'b1);
    pin_raw = 1'b0;
    wait_n(3);
    check("R2", pin_filt, 1'b0);

    // Table of mode / unit / count cases
    for (int i = 0; i < 11; i++) begin
      logic [16:0] v;
      v = VECS[i];
      cfg_mode = 2'b00;
      pin_raw  = v[8];
      wait_n(4);
      cfg_mode  = v[16:15];
      cfg_unit  = v[14:13];
      cfg_count = v[12:9];
      wait_n(1);
      pin_raw = ~v[8];
      wait_n(3);
      if (v[7:0] == 8'd0) begin
        check(row_tag(v), pin_filt, ~v[8]);
      end else begin
        ticks(int'(v[7:0]) - 1);
        check(row_tag(v), pin_filt, v[8]);
        tick();
        check(row_tag(v), pin_filt, ~v[8]);
      end
    end

    // R8 and R9: the delayed direction holds without ticks
    cfg_mode = 2'b00; pin_raw = 1'b0; wait_n(4);
    cfg_mode = 2'b10; cfg_unit = 2'b00; cfg_count = 4'd1; wait_n(1);
    pin_raw = 1'b1; wait_n(20);
    check("R8", pin_filt, 1'b0);
    cfg_mode = 2'b00; pin_raw = 1'b1; wait_n(4);
    cfg_mode = 2'b11; wait_n(1);
    pin_raw = 1'b0; wait_n(20);
    check("R9", pin_filt, 1'b1);

    // R7: a bounce back discards progress
    cfg_mode = 2'b00; pin_raw = 1'b0; wait_n(4);
    cfg_mode = 2'b01; cfg_unit = 2'b01; cfg_count = 4'd2; wait_n(1);
    pin_raw = 1'b1; wait_n(3);
    ticks(10);
    pin_raw = 1'b0; wait_n(3);
    check("R7", pin_filt, 1'b0);
    pin_raw = 1'b1; wait_n(3);
    ticks(15);
    check("R7", pin_filt, 1'b0);
    tick();
    check("R7", pin_filt, 1'b1);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule